// File: doc/BRIEF.md
# RV32C Instruction Expander

This unit turns one 16-bit compressed RISC-V instruction into the 32-bit base-integer instruction that does the same work. A decoder built only for 32-bit words can then run compressed code. The unit has no clock and no state, and its output follows its input within the same cycle. The fetch logic places the halfword on the input whenever the two low bits of that halfword are not `11`. It forwards the 32-bit result to the decoder as if it had been fetched whole.

The unit handles the integer compressed subset of the 32-bit base ISA:

- immediate loads, upper-immediate loads and adds, including the two forms scaled to the stack pointer
- word loads and stores, either relative to a register or relative to the stack pointer
- jumps and register jumps, with and without a link
- branches that compare a register with zero
- register and immediate arithmetic and logic, and immediate shifts
- the breakpoint

Any other halfword expands to the all-zero word. That word is not a legal base instruction, so the decoder's existing illegal-opcode path raises the trap with no extra signal. This covers reserved encodings, floating-point forms, 64-bit-only forms and the all-zero halfword itself.

Top module: `rvc_expand`

## Requirements
- R1: The output is 32'h0 for every halfword in these groups: low bits `00` with bits 15:13 equal to 001, 011, 100, 101 or 111; low bits `10` with bits 15:13 equal to 001, 011, 101 or 111; and any halfword whose low bits are `11`. Every nonzero output has bits 1:0 equal to `11`.
- R2: The output is 32'h0 for these reserved forms:
  - the all-zero halfword;
  - the stack-address add (low `00`, funct 000) when bits 12:5 are zero;
  - low `01`, funct 011 when bits 12 and 6:2 are all zero;
  - the stack-relative word load (low `10`, funct 010) when bits 11:7 are zero;
  - the register jump without link (low `10`, funct 100, bit 12 = 0, bits 6:2 = 0) when bits 11:7 are zero.
- R3: The output is 32'h0 for 64-bit-only forms:
  - the logical and arithmetic right shifts (low `01`, funct 100, bits 11:10 = 00 or 01) when bit 12 is set;
  - the left shift (low `10`, funct 000) when bit 12 is set;
  - the register-register group (low `01`, funct 100, bits 11:10 = 11) when bit 12 is set.
- R4: The immediate forms expand as follows. The six-bit signed immediate is {bit12, bits 6:2}.
  - The add-immediate form (low `01`, funct 000) gives ADDI rd,rd,imm, with rd in bits 11:7.
  - The load-immediate form (funct 010) gives ADDI rd,x0,imm.
  - Funct 011 with rd = x2 gives ADDI x2,x2 with a 16-scaled immediate. Its bits 9..4 come from halfword bits 12, 4, 3, 5, 2 and 6 in that order.
  - Funct 011 with any other rd gives LUI rd with a sign-extended upper immediate {bit12, bits 6:2}.
  - The stack-address form (low `00`, funct 000) gives ADDI rd',x2,imm. Its immediate bits 9..2 come from halfword bits 10, 9, 8, 7, 12, 11, 5 and 6 in that order.
- R5: Word transfers expand to LW or SW.
  - The register-relative forms (low `00`, funct 010 load, 110 store) use base {01, bits 9:7}. The data register is {01, bits 4:2}. Offset bits 6..2 come from halfword bits 5, 12, 11, 10 and 6 in that order.
  - The stack-relative forms use base x2. The load (low `10`, funct 010) takes rd from bits 11:7, and its offset bits 7..2 come from halfword bits 3, 2, 12, 6, 5 and 4 in that order.
  - The stack-relative store (funct 110) takes rs2 from bits 6:2, and its offset bits 7..2 come from halfword bits 8, 7, 12, 11, 10 and 9 in that order.
- R6: The jumps expand as follows. Low `01`, funct 101 gives JAL x0; funct 001 gives JAL x1. Both use the sign-extended 12-bit offset whose bits 11..1 come from halfword bits 12, 8, 10, 9, 6, 7, 2, 11, 5, 4 and 3 in that order. For low `10`, funct 100, with rs1 = bits 11:7 nonzero and bits 6:2 zero: bit 12 = 0 gives JALR x0,0(rs1), and bit 12 = 1 gives JALR x1,0(rs1).
- R7: Low `01`, funct 110 gives BEQ rs1',x0, and funct 111 gives BNE rs1',x0, where rs1' = {01, bits 9:7}. Both use the sign-extended 9-bit offset whose bits 8..1 come from halfword bits 12, 6, 5, 2, 11, 10, 4 and 3 in that order.
- R8: Low `01`, funct 100 selects an operation by bits 11:10: 00 gives SRLI, 01 gives SRAI and 10 gives ANDI. The shift amount or the signed immediate comes from {bit12, bits 6:2}. In all three, the destination and first source are the same register, {01, bits 9:7}.
- R9: Low `01`, funct 100, bits 11:10 = 11 and bit 12 = 0 gives a register-register operation chosen by bits 6:5: 00 gives SUB, 01 gives XOR, 10 gives OR and 11 gives AND. The destination and first source are {01, bits 9:7}. The second source is {01, bits 4:2}.
- R10: Low `10`, funct 100 also carries three other forms. With bit 12 = 0 and bits 6:2 nonzero, it gives ADD rd,x0,rs2 (move). With bit 12 = 1 and bits 6:2 nonzero, it gives ADD rd,rd,rs2. With bit 12 = 1 and bits 11:2 zero, it gives EBREAK (32'h00100073). Low `10`, funct 000 with bit 12 = 0 gives SLLI rd,rd,bits 6:2.
- R11: The output is a pure function of the current input and settles in the same cycle that the input is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| c_in | input | 16 | Compressed halfword to expand |
| x_out | output | 32 | Equivalent 32-bit instruction, or zero when unsupported |

## Verification
On every input change, the embedded assertions check these invariants:
- quadrant-three inputs and 64-bit-only shifts produce zero;
- any nonzero result has a valid 32-bit length code;
- every compressed-register operation writes {01, bits 9:7} and also reads it as the first source;
- branches compare against x0;
- a linking jump writes x1, and a plain register jump writes x0.

Only the bench's sweep shows that each immediate is scattered into the right bit positions and that every one of the 65536 halfwords matches the expected word exactly. That sweep runs against an independent behavioural model, supported by a table of known pairs.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int HW  = 16;
  localparam int IW  = 32;
  localparam int RW  = 5;
  localparam int CRW = 3;
  localparam int FW  = 3;
  localparam int OPW = 7;

  typedef logic [IW-1:0]  word_t;
  typedef logic [RW-1:0]  reg_t;
  typedef logic [FW-1:0]  f3_t;
  typedef logic [OPW-1:0] op_t;

  localparam op_t OP_LOAD  = 7'b0000011;
  localparam op_t OP_IMM   = 7'b0010011;
  localparam op_t OP_STORE = 7'b0100011;
  localparam op_t OP_REG   = 7'b0110011;
  localparam op_t OP_LUI   = 7'b0110111;
  localparam op_t OP_BR    = 7'b1100011;
  localparam op_t OP_JALR  = 7'b1100111;
  localparam op_t OP_JAL   = 7'b1101111;
  localparam word_t W_EBREAK = 32'h0010_0073;
  localparam word_t W_ZERO   = '0;

  localparam reg_t R_ZERO = 5'd0;
  localparam reg_t R_LINK = 5'd1;
  localparam reg_t R_SP   = 5'd2;

  function automatic reg_t narrow_reg(input logic [CRW-1:0] r);
    return {2'b01, r};
  endfunction

  function automatic word_t mk_i(input logic [11:0] imm, input reg_t rs1,
                                 input f3_t f3, input reg_t rd, input op_t op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic word_t mk_s(input logic [11:0] imm, input reg_t rs2,
                                 input reg_t rs1, input f3_t f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], OP_STORE};
  endfunction

  function automatic word_t mk_r(input logic [6:0] f7, input reg_t rs2,
                                 input reg_t rs1, input f3_t f3, input reg_t rd);
    return {f7, rs2, rs1, f3, rd, OP_REG};
  endfunction

  function automatic word_t mk_b(input logic [12:0] imm, input reg_t rs1, input f3_t f3);
    return {imm[12], imm[10:5], R_ZERO, rs1, f3, imm[4:1], imm[11], OP_BR};
  endfunction

  function automatic word_t mk_j(input logic [20:0] imm, input reg_t rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OP_JAL};
  endfunction

  function automatic word_t mk_u(input logic [19:0] up, input reg_t rd);
    return {up, rd, OP_LUI};
  endfunction
endpackage

// File: rtl/rvc_q0.sv
module rvc_q0 (
  input  logic [rvc_pkg::HW-1:2] h,
  output rvc_pkg::word_t         w
);
  import rvc_pkg::*;

  logic [9:0]  spn_imm;
  logic [6:0]  lw_off;
  reg_t        rb, rd;

  always_comb begin
    spn_imm = {h[10:7], h[12:11], h[5], h[6], 2'b00};
    lw_off  = {h[5], h[12:10], h[6], 2'b00};
    rb      = narrow_reg(h[9:7]);
    rd      = narrow_reg(h[4:2]);
    w       = W_ZERO;
    case (h[15:13])
      3'b000: if (spn_imm != '0) w = mk_i({2'b00, spn_imm}, R_SP, 3'b000, rd, OP_IMM);
      3'b010: w = mk_i({5'b0, lw_off}, rb, 3'b010, rd, OP_LOAD);
      3'b110: w = mk_s({5'b0, lw_off}, rd, rb, 3'b010);
      default: w = W_ZERO;
    endcase
  end

  always_comb begin
    if (!$isunknown(h)) begin
      if (h[15:13] == 3'b000 && h[12:5] == '0)
        AST_SPN_ZERO_RESERVED: assert (w == '0); // R2
      if (h[15:13] == 3'b010 || h[15:13] == 3'b110)
        AST_Q0_BASE_REG: assert (w[19:15] == {2'b01, h[9:7]}); // R5
    end
  end
endmodule

// File: rtl/rvc_q1.sv
module rvc_q1 (
  input  logic [rvc_pkg::HW-1:2] h,
  output rvc_pkg::word_t         w
);
  import rvc_pkg::*;

  logic [11:0] imm6x;
  logic [11:0] sp16;
  logic [19:0] up;
  logic [20:0] joff;
  logic [12:0] boff;
  reg_t        rd, rp1, rp2;
  logic [6:0]  sh_f7;

  always_comb begin
    imm6x = {{6{h[12]}}, h[12], h[6:2]};
    sp16  = {{2{h[12]}}, h[12], h[4:3], h[5], h[2], h[6], 4'b0000};
    up    = {{14{h[12]}}, h[12], h[6:2]};
    joff  = {{10{h[12]}}, h[8], h[10:9], h[6], h[7], h[2], h[11], h[5:3], 1'b0};
    boff  = {{5{h[12]}}, h[6:5], h[2], h[11:10], h[4:3], 1'b0};
    rd    = h[11:7];
    rp1   = narrow_reg(h[9:7]);
    rp2   = narrow_reg(h[4:2]);
    sh_f7 = h[10] ? 7'b0100000 : 7'b0000000;
    w     = W_ZERO;
    case (h[15:13])
      3'b000: w = mk_i(imm6x, rd, 3'b000, rd, OP_IMM);
      3'b001: w = mk_j(joff, R_LINK);
      3'b010: w = mk_i(imm6x, R_ZERO, 3'b000, rd, OP_IMM);
      3'b011: begin
        if (rd == R_SP) begin
          if (sp16 != '0) w = mk_i(sp16, R_SP, 3'b000, R_SP, OP_IMM);
        end else if ({h[12], h[6:2]} != '0) begin
          w = mk_u(up, rd);
        end
      end
      3'b100: begin
        case (h[11:10])
          2'b00, 2'b01:
            if (!h[12]) w = mk_i({sh_f7, h[6:2]}, rp1, 3'b101, rp1, OP_IMM);
          2'b10: w = mk_i(imm6x, rp1, 3'b111, rp1, OP_IMM);
          default: begin
            if (!h[12]) begin
              case (h[6:5])
                2'b00:   w = mk_r(7'b0100000, rp2, rp1, 3'b000, rp1);
                2'b01:   w = mk_r(7'b0000000, rp2, rp1, 3'b100, rp1);
                2'b10:   w = mk_r(7'b0000000, rp2, rp1, 3'b110, rp1);
                default: w = mk_r(7'b0000000, rp2, rp1, 3'b111, rp1);
              endcase
            end
          end
        endcase
      end
      3'b101: w = mk_j(joff, R_ZERO);
      3'b110: w = mk_b(boff, rp1, 3'b000);
      default: w = mk_b(boff, rp1, 3'b001);
    endcase
  end

  always_comb begin
    if (!$isunknown(h)) begin
      if (h[15:13] == 3'b100 && !h[11] && h[12])
        AST_SRX_RV64_ZERO: assert (w == '0); // R3
      if (h[15:13] == 3'b100 && !(h[12] && (h[11:10] != 2'b10)))
        AST_CB_CA_DEST: assert (w[11:7] == {2'b01, h[9:7]} && w[19:15] == w[11:7]); // R8
      if (h[15:13] == 3'b100 && h[11:10] == 2'b11 && !h[12])
        AST_CA_SRC2: assert (w[24:20] == {2'b01, h[4:2]} && w[6:0] == 7'b0110011); // R9
      if (h[15:14] == 2'b11)
        AST_BRANCH_VS_ZERO: assert (w[24:20] == 5'd0 && w[6:0] == 7'b1100011); // R7
      if (h[14:13] == 2'b01 && !h[15])
        AST_JAL_LINKS_RA: assert (w[11:7] == 5'd1 && w[6:0] == 7'b1101111); // R6
    end
  end
endmodule

// File: rtl/rvc_q2.sv
module rvc_q2 (
  input  logic [rvc_pkg::HW-1:2] h,
  output rvc_pkg::word_t         w
);
  import rvc_pkg::*;

  logic [7:0] ldsp_off, stsp_off;
  reg_t       rd, rs2;

  always_comb begin
    ldsp_off = {h[3:2], h[12], h[6:4], 2'b00};
    stsp_off = {h[8:7], h[12:9], 2'b00};
    rd       = h[11:7];
    rs2      = h[6:2];
    w        = W_ZERO;
    case (h[15:13])
      3'b000: if (!h[12]) w = mk_i({7'b0, h[6:2]}, rd, 3'b001, rd, OP_IMM);
      3'b010: if (rd != R_ZERO) w = mk_i({4'b0, ldsp_off}, R_SP, 3'b010, rd, OP_LOAD);
      3'b100: begin
        if (!h[12]) begin
          if (rs2 == R_ZERO) begin
            if (rd != R_ZERO) w = mk_i(12'd0, rd, 3'b000, R_ZERO, OP_JALR);
          end else begin
            w = mk_r(7'b0, rs2, R_ZERO, 3'b000, rd);
          end
        end else begin
          if (rs2 != R_ZERO)      w = mk_r(7'b0, rs2, rd, 3'b000, rd);
          else if (rd == R_ZERO)  w = W_EBREAK;
          else                    w = mk_i(12'd0, rd, 3'b000, R_LINK, OP_JALR);
        end
      end
      3'b110: w = mk_s({4'b0, stsp_off}, rs2, R_SP, 3'b010);
      default: w = W_ZERO;
    endcase
  end

  always_comb begin
    if (!$isunknown(h)) begin
      if (h[15:13] == 3'b000 && h[12])
        AST_SLLI_RV64_ZERO: assert (w == '0); // R3
      if (h[15:13] == 3'b100 && h[6:2] == 5'd0 && h[11:7] != 5'd0)
        AST_JR_LINK_REG: assert (w[6:0] == 7'b1100111 && w[11:7] == {4'b0, h[12]}); // R6
    end
  end
endmodule

// File: rtl/rvc_expand.sv
module rvc_expand (
  input  logic [rvc_pkg::HW-1:0] c_in,
  output logic [rvc_pkg::IW-1:0] x_out
);
  import rvc_pkg::*;

  word_t w0, w1, w2;

  rvc_q0 u_q0 (.h(c_in[HW-1:2]), .w(w0));
  rvc_q1 u_q1 (.h(c_in[HW-1:2]), .w(w1));
  rvc_q2 u_q2 (.h(c_in[HW-1:2]), .w(w2));

  always_comb begin
    case (c_in[1:0])
      2'b00:   x_out = w0;
      2'b01:   x_out = w1;
      2'b10:   x_out = w2;
      default: x_out = W_ZERO;
    endcase
  end

  always_comb begin
    if (!$isunknown(c_in)) begin
      AST_LEGAL_LENGTH_CODE: assert (x_out == '0 || x_out[1:0] == 2'b11); // R1
      if (c_in[1:0] == 2'b11)
        AST_FULL_WIDTH_ZERO: assert (x_out == '0); // R1
      if (c_in == '0)
        AST_ZERO_HALF_ZERO: assert (x_out == '0); // R2
    end
  end
endmodule

// File: tb/sim_rvc_expand.sv
module sim_rvc_expand;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] c_in = 16'h0;
  logic [31:0] x_out;
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  rvc_expand u0 (.c_in(c_in), .x_out(x_out));

  function automatic logic [31:0] ity(int imm, int rs1, int f3, int rd, int op);
    return 32'(((imm & 'hfff) << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op);
  endfunction
  function automatic logic [31:0] sty(int imm, int rs2, int rs1);
    return 32'((((imm >> 5) & 'h7f) << 25) | (rs2 << 20) | (rs1 << 15) | (2 << 12) |
               ((imm & 'h1f) << 7) | 'h23);
  endfunction
  function automatic logic [31:0] rty(int f7, int rs2, int rs1, int f3, int rd);
    return 32'((f7 << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | 'h33);
  endfunction
  function automatic logic [31:0] bty(int off, int rs1, int f3);
    return 32'((((off >> 12) & 1) << 31) | (((off >> 5) & 'h3f) << 25) | (rs1 << 15) |
               (f3 << 12) | (((off >> 1) & 'hf) << 8) | (((off >> 11) & 1) << 7) | 'h63);
  endfunction
  function automatic logic [31:0] jty(int off, int rd);
    return 32'((((off >> 20) & 1) << 31) | (((off >> 1) & 'h3ff) << 21) |
               (((off >> 11) & 1) << 20) | (((off >> 12) & 'hff) << 12) | (rd << 7) | 'h6f);
  endfunction

  // Behavioural reference; tag names the requirement governing the halfword.
  function automatic logic [31:0] model(input logic [15:0] h, output string tag);
    int f = int'(h[15:13]);
    int big = int'(h[11:7]);
    int lo5 = int'(h[6:2]);
    int p97 = 8 + int'(h[9:7]);
    int p42 = 8 + int'(h[4:2]);
    int s6 = h[12] ? int'(h[6:2]) - 32 : int'(h[6:2]);
    int v;
    tag = "R1";
    if (h == 16'h0) begin tag = "R2"; return 0; end
    case (h[1:0])
      2'b00: begin
        if (f == 0) begin
          v = int'(h[10:7]) * 64 + int'(h[12:11]) * 16 + int'(h[5]) * 8 + int'(h[6]) * 4;
          if (v == 0) begin tag = "R2"; return 0; end
          tag = "R4"; return ity(v, 2, 0, p42, 'h13);
        end
        v = int'(h[5]) * 64 + int'(h[12:10]) * 8 + int'(h[6]) * 4;
        if (f == 2) begin tag = "R5"; return ity(v, p97, 2, p42, 'h03); end
        if (f == 6) begin tag = "R5"; return sty(v, p42, p97); end
        return 0;
      end
      2'b01: begin
        case (f)
          0: begin tag = "R4"; return ity(s6, big, 0, big, 'h13); end
          2: begin tag = "R4"; return ity(s6, 0, 0, big, 'h13); end
          3: begin
            if (big == 2) begin
              v = int'(h[4:3]) * 128 + int'(h[5]) * 64 + int'(h[2]) * 32 + int'(h[6]) * 16;
              if (h[12]) v -= 512;
              if (v == 0) begin tag = "R2"; return 0; end
              tag = "R4"; return ity(v, 2, 0, 2, 'h13);
            end
            if (s6 == 0) begin tag = "R2"; return 0; end
            tag = "R4"; return 32'((s6 << 12) | (big << 7) | 'h37);
          end
          1, 5: begin
            v = int'(h[8]) * 1024 + int'(h[10:9]) * 256 + int'(h[6]) * 128 + int'(h[7]) * 64 +
                int'(h[2]) * 32 + int'(h[11]) * 16 + int'(h[5:3]) * 2;
            if (h[12]) v -= 2048;
            tag = "R6"; return jty(v, f == 1 ? 1 : 0);
          end
          6, 7: begin
            v = int'(h[6:5]) * 64 + int'(h[2]) * 32 + int'(h[11:10]) * 8 + int'(h[4:3]) * 2;
            if (h[12]) v -= 256;
            tag = "R7"; return bty(v, p97, f == 6 ? 0 : 1);
          end
          default: begin
            if (h[11:10] == 2'b10) begin tag = "R8"; return ity(s6, p97, 7, p97, 'h13); end
            if (h[12]) begin tag = "R3"; return 0; end
            if (h[11:10] != 2'b11) begin
              tag = "R8";
              return ity(lo5 + (h[10] ? 'h400 : 0), p97, 5, p97, 'h13);
            end
            tag = "R9";
            case (h[6:5])
              2'b00:   return rty('h20, p42, p97, 0, p97);
              2'b01:   return rty(0, p42, p97, 4, p97);
              2'b10:   return rty(0, p42, p97, 6, p97);
              default: return rty(0, p42, p97, 7, p97);
            endcase
          end
        endcase
      end
      2'b10: begin
        case (f)
          0: begin
            if (h[12]) begin tag = "R3"; return 0; end
            tag = "R10"; return ity(lo5, big, 1, big, 'h13);
          end
          2: begin
            if (big == 0) begin tag = "R2"; return 0; end
            tag = "R5";
            return ity(int'(h[3:2]) * 64 + int'(h[12]) * 32 + int'(h[6:4]) * 4, 2, 2, big, 'h03);
          end
          4: begin
            if (lo5 != 0) begin tag = "R10"; return rty(0, lo5, h[12] ? big : 0, 0, big); end
            if (!h[12]) begin
              if (big == 0) begin tag = "R2"; return 0; end
              tag = "R6"; return ity(0, big, 0, 0, 'h67);
            end
            if (big == 0) begin tag = "R10"; return 32'h0010_0073; end
            tag = "R6"; return ity(0, big, 0, 1, 'h67);
          end
          6: begin
            tag = "R5"; return sty(int'(h[8:7]) * 64 + int'(h[12:9]) * 4, lo5, 2);
          end
          default: return 0;
        endcase
      end
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    n_cmp++;
    if (x_out !== exp) begin
      n_bad++;
      $display("FAIL %s: in=%h actual=%h expected=%h", req, c_in, x_out, exp);
    end
  endtask

  // Drive after the rising edge, sample on the falling edge (R11: same cycle).
  task automatic apply(input logic [15:0] v, input string req, input logic [31:0] exp);
    @(posedge clk);
    #1 c_in = v;
    @(negedge clk);
    check(req, exp);
  endtask

  initial begin
    string t;
    logic [31:0] e;
    repeat (3) begin
      @(negedge clk);
      check("R2", 32'h0);
    end
    rst_n = 1'b1;
    // Table of known pairs
    apply(16'h1141, "R4",  32'hff01_0113);
    apply(16'h4501, "R4",  32'h0000_0513);
    apply(16'h0001, "R4",  32'h0000_0013);
    apply(16'h8082, "R6",  32'h0000_8067);
    apply(16'h9002, "R10", 32'h0010_0073);
    apply(16'h852e, "R10", 32'h00b0_0533);
    // Reserved and unsupported patterns
    apply(16'h0000, "R2", 32'h0);
    apply(16'h6101, "R2", 32'h0);
    apply(16'h6081, "R2", 32'h0);
    apply(16'h4002, "R2", 32'h0);
    apply(16'h8002, "R2", 32'h0);
    apply(16'h9001, "R3", 32'h0);
    apply(16'h9c01, "R3", 32'h0);
    apply(16'h1002, "R3", 32'h0);
    apply(16'h2000, "R1", 32'h0);
    apply(16'h2002, "R1", 32'h0);
    apply(16'hffff, "R1", 32'h0);
    // Full sweep against the reference model, one halfword per clock
    for (int i = 0; i < 65536; i++) begin
      e = model(16'(i), t);
      apply(16'(i), t, e);
    end
    // Back-to-back changes settle within a cycle
    apply(16'h8082, "R11", 32'h0000_8067);
    apply(16'h1141, "R11", 32'hff01_0113);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R11: watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule